// File: doc/BRIEF.md
# Hibernate and Wakeup Sequencer

This block is a power-control state machine that runs on the slow real-time clock. Software writes a command that cuts the power-enable output. While power is off, the block watches an active-low wakeup pin. It accepts a wakeup only after the pin has stayed low for a programmable number of ticks. A shorter pulse is treated as a glitch, and the count starts again from zero.

Once a wakeup is accepted, power is restored at once. The system reset output is then held low for a programmable number of ticks and released, and the block returns to normal running.

Three registers sit on a simple write bus with combinational read data:
- A command register at offset 0x20.
- A filter-length register at offset 0x24, which keeps only bits 15:5.
- A reset-hold register at offset 0x28, which keeps only bits 11:5.

At a 32 kHz clock, these fields give filter times up to about 2 s and reset holds up to about 125 ms.

Top module: `hib_wake_seq`

## Requirements
- R1: After the reset input is released, the block is running. `pwr_en` is 1, `sys_rst_n` is 1, and both length registers read 0.
- R2: A write to offset 0x20 with data bit 0 set, while running, switches power off: `pwr_en` is 0 from the next cycle. A write to 0x20 with bit 0 clear has no effect. So does any write to 0x20 while power is off or reset is held.
- R3: A write to offset 0x24 stores only data bits 15:5. Reads of 0x24 return the stored bits, with every other bit 0.
- R4: A write to offset 0x28 stores only data bits 11:5. Reads of 0x28 return the stored bits, with every other bit 0.
- R5: With power off, a wakeup is accepted on the N-th consecutive clock edge that samples `wake_n` at 0. N is the 0x24 value, or 1 when that value is 0. In the cycle after acceptance, `pwr_en` is 1 and `sys_rst_n` is 0.
- R6: If `wake_n` is sampled at 1 before the count reaches N, power stays off and the consecutive count restarts from zero.
- R7: `sys_rst_n` stays low for exactly M cycles and then returns high with the block running. M is the 0x28 value, or 1 when that value is 0.
- R8: `pwr_en` is 0 exactly while power is off, whether the block is idle or filtering. `sys_rst_n` is 0 only during the reset hold, and power is on whenever reset is held.
- R9: Reading 0x20 returns 1 in bit 0 while power is off and 0 otherwise, with all other bits 0. Reads of any unmapped offset return 0.
- R10: `wake_n` has no effect while the block is running or holding reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wake_n | input | 1 | Active-low wakeup pin, synchronous to `clk` |
| pwr_en | output | 1 | Power-enable output, high while powered |
| sys_rst_n | output | 1 | Active-low system reset output |

## Verification
The assertions assume the following about the inputs:
- `wake_n` and the bus inputs are already synchronous to `clk`.
- Each write lasts exactly one cycle.

They also assume that the length registers change only through the bus, so the filter and hold bounds stay consistent with the stored values. The bench meets these assumptions by driving every input on the falling edge and keeping each write strobe to a single cycle. It rewrites the length registers only while the block is running, except for one deliberate command write made during the reset hold.

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FILT_MSB = 15,
  parameter int FILT_LSB = 5,
  parameter int HOLD_MSB = 11,
  parameter int HOLD_LSB = 5,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h20,
  parameter logic [ADDR_W-1:0] FILT_OFS = 'h24,
  parameter logic [ADDR_W-1:0] HOLD_OFS = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wake_n,
  output logic              pwr_en,
  output logic              sys_rst_n
);

  localparam int CNT_W = ((FILT_MSB > HOLD_MSB) ? FILT_MSB : HOLD_MSB) + 1;
  localparam logic [DATA_W-1:0] FILT_MASK =
    DATA_W'(((64'd1 << (FILT_MSB + 1)) - 64'd1) & ~((64'd1 << FILT_LSB) - 64'd1));
  localparam logic [DATA_W-1:0] HOLD_MASK =
    DATA_W'(((64'd1 << (HOLD_MSB + 1)) - 64'd1) & ~((64'd1 << HOLD_LSB) - 64'd1));

  typedef enum logic [1:0] {S_RUN, S_OFF, S_FILT, S_HOLD} state_t;

  state_t             state, state_d;
  logic [CNT_W-1:0]   cnt, cnt_d;
  logic [DATA_W-1:0]  filt_q, hold_q;

  wire              cmd_off  = bus_wr && (bus_addr == CMD_OFS) && bus_wdata[0];
  wire [CNT_W-1:0]  filt_raw = filt_q[CNT_W-1:0];
  wire [CNT_W-1:0]  hold_raw = hold_q[CNT_W-1:0];
  wire [CNT_W-1:0]  filt_len = (filt_raw == '0) ? CNT_W'(1) : filt_raw;
  wire [CNT_W-1:0]  hold_len = (hold_raw == '0) ? CNT_W'(1) : hold_raw;
  wire [CNT_W-1:0]  cnt_nx   = cnt + CNT_W'(1);

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    case (state)
      S_RUN: if (cmd_off) begin
        state_d = S_OFF;
        cnt_d   = '0;
      end
      S_OFF, S_FILT: begin
        if (!wake_n) begin
          if (cnt_nx >= filt_len) begin
            state_d = S_HOLD;
            cnt_d   = '0;
          end else begin
            state_d = S_FILT;
            cnt_d   = cnt_nx;
          end
        end else begin
          state_d = S_OFF;
          cnt_d   = '0;
        end
      end
      S_HOLD: begin
        if (cnt_nx >= hold_len) begin
          state_d = S_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_nx;
        end
      end
      default: begin
        state_d = S_RUN;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_RUN;
      cnt    <= '0;
      filt_q <= '0;
      hold_q <= '0;
    end else begin
      state <= state_d;
      cnt   <= cnt_d;
      if (bus_wr && bus_addr == FILT_OFS) filt_q <= bus_wdata & FILT_MASK;
      if (bus_wr && bus_addr == HOLD_OFS) hold_q <= bus_wdata & HOLD_MASK;
    end
  end

  assign pwr_en    = !(state == S_OFF || state == S_FILT);
  assign sys_rst_n = (state != S_HOLD);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CMD_OFS)       bus_rdata[0] = !pwr_en;
    else if (bus_addr == FILT_OFS) bus_rdata = filt_q;
    else if (bus_addr == HOLD_OFS) bus_rdata = hold_q;
  end

  assert_off_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && cmd_off) |=> !pwr_en);

  assert_run_keeps_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !cmd_off) |=> (pwr_en && sys_rst_n));

  assert_pin_high_no_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en && wake_n) |=> (!pwr_en && cnt == '0));

  assert_filter_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILT) |-> (cnt < filt_len && cnt != '0));

  assert_hold_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> (cnt < hold_len));

  assert_hold_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> pwr_en);

  assert_hold_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && cnt_nx >= hold_len) |=> (sys_rst_n && pwr_en));

endmodule

// File: tb/hib_wake_seq_bench.sv
module hib_wake_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h20;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_n = 1'b1;
  logic        pwr_en, sys_rst_n;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  int ms = 0, mc = 0, mf = 0, mr = 0;

  always #4 clk = ~clk;

  hib_wake_seq u_hib_wake_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_n(wake_n),
    .pwr_en(pwr_en), .sys_rst_n(sys_rst_n));

  task automatic chk(input longint got, input longint exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic longint exp_rd(input logic [7:0] a);
    case (a)
      8'h20: return (ms == 1 || ms == 2) ? 1 : 0;
      8'h24: return mf;
      8'h28: return mr;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int nf, nr;
    nf = (mf == 0) ? 1 : mf;
    nr = (mr == 0) ? 1 : mr;
    if (!rst_n) begin
      ms = 0; mc = 0; mf = 0; mr = 0;
      return;
    end
    case (ms)
      0: if (bus_wr && bus_addr == 8'h20 && bus_wdata[0]) begin ms = 1; mc = 0; end
      1, 2: begin
        if (!wake_n) begin
          if (mc + 1 >= nf) begin ms = 3; mc = 0; end
          else begin ms = 2; mc = mc + 1; end
        end else begin
          ms = 1; mc = 0;
        end
      end
      default: begin
        if (mc + 1 >= nr) begin ms = 0; mc = 0; end
        else mc = mc + 1;
      end
    endcase
    if (bus_wr && bus_addr == 8'h24) mf = bus_wdata & 32'h0000FFE0;
    if (bus_wr && bus_addr == 8'h28) mr = bus_wdata & 32'h00000FE0;
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    model_step();
    @(negedge clk);
    chk(pwr_en, (ms == 1 || ms == 2) ? 0 : 1, "R8 pwr_en");
    chk(sys_rst_n, (ms == 3) ? 0 : 1, "R7 sys_rst_n");
    chk(bus_rdata, exp_rd(bus_addr), "R9 rdata");
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_addr = 8'h20; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input longint exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata, exp, tag);
    bus_addr = 8'h20;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wake_measure(input int exp_f, input int exp_r, input string tf, input string tr);
    int n;
    n = 0;
    wake_n = 1'b0;
    while (pwr_en == 1'b0 && n < 70000) begin tick(); n++; end
    chk(n, exp_f, tf);
    chk(sys_rst_n, 0, tf);
    wake_n = 1'b1;
    n = 0;
    while (sys_rst_n == 1'b0 && n < 5000) begin tick(); n++; end
    chk(n, exp_r, tr);
    chk(pwr_en, 1, tr);
  endtask

  initial begin
    while (!done && cyc < 190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (R1..) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(pwr_en, 1, "R1 pwr_en");
    chk(sys_rst_n, 1, "R1 sys_rst_n");
    rd_chk(8'h24, 0, "R1 filter reg");
    rd_chk(8'h28, 0, "R1 hold reg");

    // R3 R4 masks, R9 unmapped
    wr(8'h24, 32'hFFFF_FFFF);
    rd_chk(8'h24, 32'h0000_FFE0, "R3 filter mask");
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk(8'h28, 32'h0000_0FE0, "R4 hold mask");
    wr(8'h24, 32'h0000_005F);
    rd_chk(8'h24, 32'h0000_0040, "R3 low bits dropped");
    wr(8'h28, 32'h0001_0020);
    rd_chk(8'h28, 32'h0000_0020, "R4 high bits dropped");
    rd_chk(8'h34, 0, "R9 unmapped");
    rd_chk(8'h20, 0, "R9 cmd read while running");

    // R2 bit0 clear ignored; R10 pin ignored in run
    wr(8'h20, 32'hFFFF_FFFE);
    chk(pwr_en, 1, "R2 bit0 clear ignored");
    wake_n = 1'b0;
    idle(5);
    chk(pwr_en, 1, "R10 pin in run");
    chk(sys_rst_n, 1, "R10 pin in run");
    wake_n = 1'b1;

    // R2 entry, R6 glitch restart, R5/R7 lengths 64/32
    wr(8'h20, 32'h1);
    chk(pwr_en, 0, "R2 power off");
    rd_chk(8'h20, 1, "R9 cmd read while off");
    wr(8'h20, 32'h1);
    chk(pwr_en, 0, "R2 repeat command while off");
    wake_n = 1'b0;
    idle(63);
    wake_n = 1'b1;
    tick();
    chk(pwr_en, 0, "R6 glitch rejected");
    idle(3);
    wake_measure(64, 32, "R5 filter 64", "R7 hold 32");

    // zero lengths act as one; command during hold ignored
    wr(8'h24, 0);
    wr(8'h28, 0);
    wr(8'h20, 1);
    wake_measure(1, 1, "R5 filter zero", "R7 hold zero");

    wr(8'h28, 32'h40);
    wr(8'h20, 1);
    wake_n = 1'b0;
    tick();
    chk(sys_rst_n, 0, "R5 immediate accept");
    wake_n = 1'b1;
    wr(8'h20, 1);
    chk(pwr_en, 1, "R2 command during hold ignored");
    wake_n = 1'b0;
    idle(70);
    chk(pwr_en, 1, "R10 pin in hold");
    chk(sys_rst_n, 1, "R7 hold done");
    wake_n = 1'b1;

    // maximum lengths
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h20, 1);
    wake_measure(65504, 4064, "R5 filter max", "R7 hold max");
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule